// File: doc/BRIEF.md
# I/O Address and Pseudo-Cycle Sequencer

This block sits in the bus interface of a CPU and carries out one I/O operation per request from the core. The core hands it a decoded operation: a three-bit address-mode code, four immediate bytes (k, l, m, n), the accumulator byte, the 32-bit BC register and a write flag. The block forms the 32-bit I/O address from these, registers it onto the address bus, and then runs one of two sequences. An external operation is a fixed-length bus transaction with an active-low I/O request and an active-low read or write strobe. An operation aimed at the on-chip register space is a short pseudo transaction: the register index appears on the low address byte, the upper address bits are zero and every bus control stays inactive. Meanwhile the block strobes the on-chip register file.

Each accepted request produces exactly one transaction and a single-cycle done pulse in its final cycle. While a transaction is running, the block ignores further requests.

Top module: `io_pseudo_seq`

## Requirements
- R1: Mode code 0 (accumulator form) drives the address {16'h0000, acc_i, imm_n_i}.
- R2: Mode code 1 (register indirect and block I/O) drives bc_i on the full address. The unused codes 6 and 7 also select this format.
- R3: Mode code 2 (short immediate) drives the address {16'h0000, imm_m_i, imm_n_i}.
- R4: Mode code 3 (24-bit extended) drives {8'h00, imm_l_i, imm_m_i, imm_n_i}, and mode code 4 (32-bit extended) drives {imm_k_i, imm_l_i, imm_m_i, imm_n_i}.
- R5: Mode code 5 (on-chip register access) drives {24'h000000, imm_n_i} and places imm_n_i on reg_idx_o.
- R6: An on-chip pseudo transaction keeps busy_o high for exactly 2 cycles. During those cycles ioreq_n_o, rd_n_o and wr_n_o all stay high.
- R7: An external transaction holds ioreq_n_o low for exactly 3 cycles. During the same 3 cycles it holds rd_n_o low (when is_write_i=0) or wr_n_o low (when is_write_i=1), never both.
- R8: In the second cycle of a pseudo transaction, reg_wr_o pulses for one cycle if the operation is a write, or reg_rd_o pulses (the read capture point) if it is a read.
- R9: done_o is high for exactly one cycle, in the last cycle of each transaction. busy_o falls in the cycle after.
- R10: A start_i that arrives while busy_o is high is ignored. The address and the length of the running transaction are unchanged.
- R11: After reset, ioreq_n_o, rd_n_o and wr_n_o are high, and busy_o, done_o, reg_wr_o, reg_rd_o and addr_o are zero.
- R12: addr_o holds steady throughout a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request for a new I/O operation |
| mode_i | input | 3 | Address-mode code |
| is_write_i | input | 1 | 1 = output operation, 0 = input operation |
| imm_k_i | input | 8 | Immediate byte k (bits 31:24 of the 32-bit form) |
| imm_l_i | input | 8 | Immediate byte l |
| imm_m_i | input | 8 | Immediate byte m |
| imm_n_i | input | 8 | Immediate byte n (low address byte) |
| acc_i | input | 8 | Accumulator byte |
| bc_i | input | 32 | BC register contents |
| addr_o | output | 32 | Registered I/O address |
| ioreq_n_o | output | 1 | Active-low I/O request |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| reg_idx_o | output | 8 | On-chip register index |
| reg_wr_o | output | 1 | On-chip register write strobe |
| reg_rd_o | output | 1 | On-chip register read capture strobe |

## Verification
The assertions assume that reset is held for at least one clock edge before any request, and that mode_i and the operand inputs are valid whenever start_i is high. They place no demands on the inputs while a transaction runs. The bench drives every input on the falling clock edge and holds the operand values steady for the whole accepting cycle. In the ignore test it changes the mode and the operands on purpose while busy_o is high, so that a wrongly accepted request would show up on addr_o.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_ACC   = 3'd0,
    MODE_BCREG = 3'd1,
    MODE_SHORT = 3'd2,
    MODE_EXT24 = 3'd3,
    MODE_EXT32 = 3'd4,
    MODE_CHIP  = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } io_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] k;
    logic [BYTE_W-1:0] l;
    logic [BYTE_W-1:0] m;
    logic [BYTE_W-1:0] n;
  } imm_bytes_t;
endpackage

// File: rtl/io_addr_former.sv
module io_addr_former
  import io_seq_pkg::*;
(
  input  io_mode_e            mode,
  input  imm_bytes_t          imm,
  input  logic [BYTE_W-1:0]   acc,
  input  logic [ADDR_W-1:0]   bc,
  output logic [ADDR_W-1:0]   addr,
  output logic                is_chip
);
  localparam logic [BYTE_W-1:0] ZB = '0;

  always_comb begin
    is_chip = 1'b0;
    case (mode)
      MODE_ACC:   addr = {ZB, ZB, acc, imm.n};
      MODE_SHORT: addr = {ZB, ZB, imm.m, imm.n};
      MODE_EXT24: addr = {ZB, imm.l, imm.m, imm.n};
      MODE_EXT32: addr = {imm.k, imm.l, imm.m, imm.n};
      MODE_CHIP: begin
        addr    = {ZB, ZB, ZB, imm.n};
        is_chip = 1'b1;
      end
      default:    addr = bc;
    endcase
  end
endmodule

// File: rtl/io_seq_fsm.sv
module io_seq_fsm #(
  parameter int EXT_CYCLES    = 3,
  parameter int PSEUDO_CYCLES = 2,
  localparam int MAXLEN = (EXT_CYCLES > PSEUDO_CYCLES) ? EXT_CYCLES : PSEUDO_CYCLES,
  localparam int CW     = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          chip_req,
  input  logic          wr_req,
  output logic          accept,
  output logic          busy_q,
  output logic          int_q,
  output logic          busy_d,
  output logic          int_d,
  output logic          wr_d,
  output logic [CW-1:0] cnt_d,
  output logic          last_d
);
  localparam logic [CW-1:0] EXT_LAST = CW'(EXT_CYCLES - 1);
  localparam logic [CW-1:0] INT_LAST = CW'(PSEUDO_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          wr_q;
  logic          last_q;

  assign accept = start && !busy_q;
  assign last_q = busy_q && (cnt_q == (int_q ? INT_LAST : EXT_LAST));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    int_d  = int_q;
    wr_d   = wr_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      int_d  = chip_req;
      wr_d   = wr_req;
    end else if (last_q) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign last_d = busy_d && (cnt_d == (int_d ? INT_LAST : EXT_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      int_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      int_q  <= int_d;
      wr_q   <= wr_d;
    end
  end
endmodule

// File: rtl/io_bus_drive.sv
module io_bus_drive
  import io_seq_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BYTE_W-1:0] idx_in,
  input  logic              busy_d,
  input  logic              int_d,
  input  logic              wr_d,
  input  logic [CW-1:0]     cnt_d,
  input  logic              last_d,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] reg_idx_o,
  output logic              ioreq_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic              done_o
);
  localparam logic [CW-1:0] STROBE_CNT = CW'(1);

  logic ext_act, int_strobe;
  assign ext_act    = busy_d && !int_d;
  assign int_strobe = busy_d && int_d && (cnt_d == STROBE_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o    <= '0;
      reg_idx_o <= '0;
      ioreq_n_o <= 1'b1;
      rd_n_o    <= 1'b1;
      wr_n_o    <= 1'b1;
      reg_wr_o  <= 1'b0;
      reg_rd_o  <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      if (accept) begin
        addr_o    <= addr_in;
        reg_idx_o <= idx_in;
      end
      ioreq_n_o <= !ext_act;
      rd_n_o    <= !(ext_act && !wr_d);
      wr_n_o    <= !(ext_act && wr_d);
      reg_wr_o  <= int_strobe && wr_d;
      reg_rd_o  <= int_strobe && !wr_d;
      done_o    <= last_d;
    end
  end
endmodule

// File: rtl/io_pseudo_seq.sv
module io_pseudo_seq
  import io_seq_pkg::*;
#(
  parameter int EXT_CYCLES    = 3,
  parameter int PSEUDO_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_write_i,
  input  logic [BYTE_W-1:0] imm_k_i,
  input  logic [BYTE_W-1:0] imm_l_i,
  input  logic [BYTE_W-1:0] imm_m_i,
  input  logic [BYTE_W-1:0] imm_n_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [ADDR_W-1:0] bc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ioreq_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] reg_idx_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o
);
  localparam int MAXLEN = (EXT_CYCLES > PSEUDO_CYCLES) ? EXT_CYCLES : PSEUDO_CYCLES;
  localparam int CW     = $clog2(MAXLEN + 1);

  imm_bytes_t        imm;
  logic [ADDR_W-1:0] addr_next;
  logic              chip_req, accept, busy_q, int_q;
  logic              busy_d, int_d, wr_d, last_d;
  logic [CW-1:0]     cnt_d;

  assign imm = '{k: imm_k_i, l: imm_l_i, m: imm_m_i, n: imm_n_i};

  io_addr_former u_addr (
    .mode    (io_mode_e'(mode_i)),
    .imm     (imm),
    .acc     (acc_i),
    .bc      (bc_i),
    .addr    (addr_next),
    .is_chip (chip_req)
  );

  io_seq_fsm #(.EXT_CYCLES(EXT_CYCLES), .PSEUDO_CYCLES(PSEUDO_CYCLES)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .chip_req (chip_req),
    .wr_req   (is_write_i),
    .accept   (accept),
    .busy_q   (busy_q),
    .int_q    (int_q),
    .busy_d   (busy_d),
    .int_d    (int_d),
    .wr_d     (wr_d),
    .cnt_d    (cnt_d),
    .last_d   (last_d)
  );

  io_bus_drive #(.CW(CW)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .addr_in   (addr_next),
    .idx_in    (imm_n_i),
    .busy_d    (busy_d),
    .int_d     (int_d),
    .wr_d      (wr_d),
    .cnt_d     (cnt_d),
    .last_d    (last_d),
    .addr_o    (addr_o),
    .reg_idx_o (reg_idx_o),
    .ioreq_n_o (ioreq_n_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .reg_wr_o  (reg_wr_o),
    .reg_rd_o  (reg_rd_o),
    .done_o    (done_o)
  );

  assign busy_o = busy_q;
endmodule

// File: rtl/io_pseudo_seq_chk.sv
module io_pseudo_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        is_int,
  input logic        done,
  input logic        ioreq_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [31:0] addr
);
  // R6: bus controls inactive during a pseudo transaction
  a_r6_ctrl_idle: assert property (@(posedge clk) disable iff (rst)
    (busy && is_int) |-> (ioreq_n && rd_n && wr_n));

  // R5: upper address forced to zero for on-chip access
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (busy && is_int) |-> (addr[31:8] == 24'h0));

  // R7: never both strobes; a strobe only inside a request
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  a_r7_strobe_in_req: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !ioreq_n);

  // R9: done pulse lies within a transaction and ends it
  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  a_r9_done_ends: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy && !done);

  // R8: register strobes only during a pseudo transaction, never together
  a_r8_reg_strobe: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd) |-> (busy && is_int && !(reg_wr && reg_rd)));

  // R12: address steady while a transaction continues
  a_r12_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(done)) |-> $stable(addr));
endmodule

bind io_pseudo_seq io_pseudo_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy_o),
  .is_int  (int_q),
  .done    (done_o),
  .ioreq_n (ioreq_n_o),
  .rd_n    (rd_n_o),
  .wr_n    (wr_n_o),
  .reg_wr  (reg_wr_o),
  .reg_rd  (reg_rd_o),
  .addr    (addr_o)
);

// File: tb/io_pseudo_seq_tb.sv
module io_pseudo_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        is_write_i = 1'b0;
  logic [7:0]  imm_k_i = 8'h0, imm_l_i = 8'h0, imm_m_i = 8'h0, imm_n_i = 8'h0;
  logic [7:0]  acc_i = 8'h0;
  logic [31:0] bc_i = 32'h0;
  logic [31:0] addr_o;
  logic        ioreq_n_o, rd_n_o, wr_n_o, busy_o, done_o, reg_wr_o, reg_rd_o;
  logic [7:0]  reg_idx_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  io_pseudo_seq u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // observation record of one transaction
  logic [31:0] o_addr1, o_addr3;
  logic [7:0]  o_idx;
  int n_req, n_rd, n_wr, n_busy, n_done, done_cyc, n_rw, n_rr, strobe_cyc, n_ctrl_int;

  task automatic run_op(input logic [2:0] mode, input bit wr, input logic [7:0] k,
                        input logic [7:0] l, input logic [7:0] m, input logic [7:0] n,
                        input logic [7:0] a, input logic [31:0] bc, input int hold);
    @(negedge clk);
    mode_i = mode; is_write_i = wr; imm_k_i = k; imm_l_i = l; imm_m_i = m;
    imm_n_i = n; acc_i = a; bc_i = bc; start_i = 1'b1;
    n_req = 0; n_rd = 0; n_wr = 0; n_busy = 0; n_done = 0; done_cyc = 0;
    n_rw = 0; n_rr = 0; strobe_cyc = 0; n_ctrl_int = 0;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if (c == 1) begin o_addr1 = addr_o; o_idx = reg_idx_o; end
      if (c == 3) o_addr3 = addr_o;
      if (!ioreq_n_o) n_req++;
      if (!rd_n_o) n_rd++;
      if (!wr_n_o) n_wr++;
      if (busy_o) n_busy++;
      if (done_o) begin n_done++; done_cyc = c; end
      if (reg_wr_o) begin n_rw++; strobe_cyc = c; end
      if (reg_rd_o) begin n_rr++; strobe_cyc = c; end
      if (c >= hold) start_i = 1'b0;
      else begin
        mode_i = 3'd2; imm_m_i = ~m; imm_n_i = ~n;
      end
    end
  endtask

  task automatic check_ext(input string req, input bit wr, input logic [31:0] exp_addr);
    check(o_addr1 == exp_addr, req, o_addr1, exp_addr);
    check(n_req == 3, "R7 ioreq length", n_req, 3);
    check(wr ? (n_wr == 3 && n_rd == 0) : (n_rd == 3 && n_wr == 0), "R7 strobe",
          wr ? n_wr : n_rd, 3);
    check(n_done == 1 && done_cyc == 3, "R9 done pulse", done_cyc, 3);
    check(n_busy == 3, "R9 busy length", n_busy, 3);
    check(n_rw == 0 && n_rr == 0, "R8 no reg strobe on external", n_rw + n_rr, 0);
  endtask

  task automatic t_reset();
    check(ioreq_n_o && rd_n_o && wr_n_o, "R11 controls high", {ioreq_n_o, rd_n_o, wr_n_o}, 3'b111);
    check(!busy_o && !done_o && !reg_wr_o && !reg_rd_o, "R11 flags low",
          {busy_o, done_o, reg_wr_o, reg_rd_o}, 0);
    check(addr_o == 0, "R11 addr zero", addr_o, 0);
  endtask

  task automatic t_acc();
    run_op(3'd0, 1'b0, 8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 32'hDEADBEEF, 1);
    check_ext("R1 acc address", 1'b0, 32'h0000A544);
  endtask

  task automatic t_bc();
    run_op(3'd1, 1'b1, 8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 32'hCAFE1234, 1);
    check_ext("R2 bc address", 1'b1, 32'hCAFE1234);
    run_op(3'd6, 1'b0, 8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 32'h89ABCDEF, 1);
    check(o_addr1 == 32'h89ABCDEF, "R2 code 6 as bc", o_addr1, 32'h89ABCDEF);
    run_op(3'd7, 1'b1, 8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 32'h01020304, 1);
    check(o_addr1 == 32'h01020304, "R2 code 7 as bc", o_addr1, 32'h01020304);
  endtask

  task automatic t_short();
    run_op(3'd2, 1'b1, 8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 32'hFFFFFFFF, 1);
    check_ext("R3 short address", 1'b1, 32'h00003344);
  endtask

  task automatic t_ext();
    run_op(3'd3, 1'b0, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'h00, 32'h0, 1);
    check_ext("R4 ext24 address", 1'b0, 32'h00BCDEF0);
    run_op(3'd4, 1'b1, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'h00, 32'h0, 1);
    check_ext("R4 ext32 address", 1'b1, 32'h9ABCDEF0);
  endtask

  task automatic t_chip(input bit wr);
    run_op(3'd5, wr, 8'hFF, 8'hEE, 8'hDD, 8'h3C, 8'hBB, 32'hFFFFFFFF, 1);
    check(o_addr1 == 32'h0000003C, "R5 chip address", o_addr1, 32'h3C);
    check(o_idx == 8'h3C, "R5 reg index", o_idx, 8'h3C);
    check(n_busy == 2, "R6 pseudo length", n_busy, 2);
    check(n_req == 0 && n_rd == 0 && n_wr == 0, "R6 controls inactive",
          n_req + n_rd + n_wr, 0);
    check(wr ? (n_rw == 1 && n_rr == 0) : (n_rr == 1 && n_rw == 0), "R8 strobe kind",
          wr ? n_rw : n_rr, 1);
    check(strobe_cyc == 2, "R8 strobe cycle", strobe_cyc, 2);
    check(n_done == 1 && done_cyc == 2, "R9 pseudo done", done_cyc, 2);
  endtask

  task automatic t_ignore();
    run_op(3'd4, 1'b0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 32'h0, 3);
    check(o_addr3 == 32'h12345678, "R10 addr unchanged", o_addr3, 32'h12345678);
    check(n_req == 3 && n_busy == 3, "R10 single transaction", n_busy, 3);
    check(n_done == 1, "R10 single done", n_done, 1);
    check(o_addr1 == o_addr3, "R12 addr stable", o_addr3, o_addr1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_acc();
    t_bc();
    t_short();
    t_ext();
    t_chip(1'b1);
    t_chip(1'b0);
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule